// File: doc/BRIEF.md
# Frame Alignment Offset Meter

This block finds how late an external frame-evaluation strobe arrives after the local frame boundary. Software sets a start bit. The meter then waits for the next local frame pulse, which marks the boundary. From that point it counts serial-clock cycles until the first qualifying edge on the evaluation input. The count is frozen together with the serial-clock level seen at that moment, which gives a half-cycle phase bit, and a completion flag is raised. A mode input sets the edge polarity. In the default bus mode a falling edge qualifies. In the alternative (GCI) mode a rising edge qualifies.

All logic runs on one fast system clock, at least four times the serial-clock rate. The serial clock, frame pulse and evaluation input each pass through a synchroniser chain of the same depth, then through an edge detector, so their relative timing is preserved. The result is read as a 16-bit status word. That word returns to zero when the start bit is taken away.

Top module: `frame_offset_meter`

## Requirements
- R1: After reset the status word reads 0x0000, and bits 15 to 13 read zero at all times.
- R2: With `gci_mode_i` = 0, a falling edge on `fe_i` ends the measurement. Bits 10:0 hold the number of serial-clock rising edges counted since the frame boundary. The boundary is the rising edge of `frame_i`, and the sclk rising edge that coincides with it is not counted.
- R3: With `gci_mode_i` = 1, a rising edge on `fe_i` ends the measurement, and the offset is counted the same way as in R2.
- R4: Bit 11 holds the level of `sclk_i` at the time the ending edge was seen: 1 when high, 0 when low.
- R5: Bit 12 goes to 1 exactly when a measurement has ended and bits 11:0 are valid. Until then bits 12:0 read zero.
- R6: Once bit 12 is set, further edges on `fe_i` of either polarity leave the word unchanged until the start bit is taken away.
- R7: After `start_i` rises, edges on `fe_i` that arrive before the next frame boundary are ignored. The count begins at 0 on that boundary, so an edge in the boundary's own serial-clock cycle reads offset 0.
- R8: When `start_i` goes from 1 to 0, the status word reads 0x0000 from then on until a new measurement ends.
- R9: The offset saturates at 2047. An edge seen while the count is 2047 is still captured. If the count would pass 2047 with no edge, the flag stays 0, and later edges leave the word at 0x0000 until the start bit is cycled.
- R10: An edge of the non-selected polarity on `fe_i` never ends a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial bit clock, asynchronous to `clk` |
| frame_i | input | 1 | Local frame pulse, active high; its rising edge is the boundary |
| fe_i | input | 1 | Frame evaluation input to be measured |
| start_i | input | 1 | Start control; high arms a measurement, falling clears the result |
| gci_mode_i | input | 1 | 0: falling edge qualifies; 1: rising edge qualifies |
| status_o | output | 16 | {3'b000, done, phase, offset[10:0]} |

## Verification
The bench builds the meter with its default parameters: an 11-bit offset, two synchroniser stages and a 16-bit word, with a serial clock of eight system cycles. With these values the full 2047-cycle counting range can be reached in about sixteen thousand system cycles. This covers both the largest capturable offset and the expiry case, together with offset 0 at the boundary and edges in either clock phase in both polarity modes.

// File: rtl/fam_pkg.sv
package fam_pkg;

   typedef enum logic [2:0] {
      MS_IDLE,
      MS_ARMED,
      MS_COUNT,
      MS_DONE,
      MS_EXPIRED
   } meas_state_t;

   localparam logic EDGE_FALLING = 1'b0;
   localparam logic EDGE_RISING  = 1'b1;

endpackage

// File: rtl/fam_sync.sv
module fam_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= chain_q[STAGES-1];
   end

   assign q_o    = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~last_q;
   assign fall_o = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/fam_counter.sv
module fam_counter #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear_i,
   input  logic             en_i,
   input  logic             tick_i,
   output logic [WIDTH-1:0] count_o,
   output logic             sat_o
);
   localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clear_i)
         cnt_q <= '0;
      else if (en_i && tick_i && (cnt_q != CNT_MAX))
         cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;
   assign sat_o   = (cnt_q == CNT_MAX);

endmodule

// File: rtl/fam_ctrl.sv
module fam_ctrl
   import fam_pkg::*;
#(
   parameter int OFFSET_W = 11
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start_i,
   input  logic                frame_edge_i,
   input  logic                meas_edge_i,
   input  logic                sclk_lvl_i,
   input  logic                sclk_tick_i,
   input  logic                sat_i,
   input  logic [OFFSET_W-1:0] count_i,
   output logic                cnt_clear_o,
   output logic                cnt_en_o,
   output logic                done_o,
   output logic                phase_o,
   output logic [OFFSET_W-1:0] offset_o
);
   meas_state_t         st_q, st_d;
   logic                start_q;
   logic                start_fall;
   logic                capture;
   logic                done_q, phase_q;
   logic [OFFSET_W-1:0] offset_q;

   assign start_fall = start_q & ~start_i;
   assign capture    = (st_q == MS_COUNT) && meas_edge_i && start_i;

   always_comb begin
      st_d = st_q;
      case (st_q)
         MS_IDLE:  if (start_i) st_d = MS_ARMED;
         MS_ARMED: if (frame_edge_i) st_d = MS_COUNT;
         MS_COUNT: begin
            if (meas_edge_i)               st_d = MS_DONE;
            else if (sat_i && sclk_tick_i) st_d = MS_EXPIRED;
         end
         default: ;
      endcase
      if (!start_i) st_d = MS_IDLE;
   end

   assign cnt_clear_o = (st_q == MS_IDLE) || ((st_q == MS_ARMED) && frame_edge_i);
   assign cnt_en_o    = (st_q == MS_COUNT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= MS_IDLE;
         start_q  <= 1'b0;
         done_q   <= 1'b0;
         phase_q  <= 1'b0;
         offset_q <= '0;
      end else begin
         st_q    <= st_d;
         start_q <= start_i;
         if (start_fall) begin
            done_q   <= 1'b0;
            phase_q  <= 1'b0;
            offset_q <= '0;
         end else if (capture) begin
            done_q   <= 1'b1;
            phase_q  <= sclk_lvl_i;
            offset_q <= count_i;
         end
      end
   end

   assign done_o   = done_q;
   assign phase_o  = phase_q;
   assign offset_o = offset_q;

endmodule

// File: rtl/frame_offset_meter.sv
module frame_offset_meter
   import fam_pkg::*;
#(
   parameter int OFFSET_W    = 11,
   parameter int SYNC_STAGES = 2,
   parameter int STATUS_W    = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                sclk_i,
   input  logic                frame_i,
   input  logic                fe_i,
   input  logic                start_i,
   input  logic                gci_mode_i,
   output logic [STATUS_W-1:0] status_o
);
   localparam int FIELD_W = OFFSET_W + 2;
   localparam int PAD_W   = STATUS_W - FIELD_W;

   generate
      if (STATUS_W < FIELD_W) begin : g_bad_width
         $error("status word too narrow for offset, phase and flag");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("at least one synchroniser stage is required");
      end
   endgenerate

   logic sclk_lvl, sclk_rise, sclk_fall_unused;
   logic frame_lvl_unused, frame_rise, frame_fall_unused;
   logic fe_lvl_unused, fe_rise, fe_fall;
   logic meas_edge;
   logic cnt_clear, cnt_en, cnt_sat;
   logic [OFFSET_W-1:0] cnt_val;
   logic done, phase;
   logic [OFFSET_W-1:0] offset;

   fam_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
      .clk(clk), .rst(rst), .d_i(sclk_i),
      .q_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall_unused)
   );

   fam_sync #(.STAGES(SYNC_STAGES)) u_sync_frame (
      .clk(clk), .rst(rst), .d_i(frame_i),
      .q_o(frame_lvl_unused), .rise_o(frame_rise), .fall_o(frame_fall_unused)
   );

   fam_sync #(.STAGES(SYNC_STAGES)) u_sync_fe (
      .clk(clk), .rst(rst), .d_i(fe_i),
      .q_o(fe_lvl_unused), .rise_o(fe_rise), .fall_o(fe_fall)
   );

   assign meas_edge = (gci_mode_i == EDGE_RISING) ? fe_rise : fe_fall;

   fam_counter #(.WIDTH(OFFSET_W)) u_count (
      .clk(clk), .rst(rst), .clear_i(cnt_clear), .en_i(cnt_en),
      .tick_i(sclk_rise), .count_o(cnt_val), .sat_o(cnt_sat)
   );

   fam_ctrl #(.OFFSET_W(OFFSET_W)) u_ctrl (
      .clk(clk), .rst(rst), .start_i(start_i),
      .frame_edge_i(frame_rise), .meas_edge_i(meas_edge),
      .sclk_lvl_i(sclk_lvl), .sclk_tick_i(sclk_rise), .sat_i(cnt_sat),
      .count_i(cnt_val), .cnt_clear_o(cnt_clear), .cnt_en_o(cnt_en),
      .done_o(done), .phase_o(phase), .offset_o(offset)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign status_o = {{PAD_W{1'b0}}, done, phase, offset};
      end else begin : g_nopad
         assign status_o = {done, phase, offset};
      end
   endgenerate

endmodule

// File: rtl/fam_checker.sv
module fam_checker #(
   parameter int OFFSET_W = 11,
   parameter int STATUS_W = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                start_i,
   input logic [STATUS_W-1:0] status_o
);
   localparam int DONE_BIT  = OFFSET_W + 1;
   localparam int PHASE_BIT = OFFSET_W;

   p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
      !start_i |=> (status_o == '0))
      else $error("status not clear after start low");

   p_fall_clears_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(start_i) |=> (status_o == '0))
      else $error("status not cleared by start falling");

   p_result_frozen_r6: assert property (@(posedge clk) disable iff (rst)
      (status_o[DONE_BIT] && start_i) |=> (status_o == $past(status_o)))
      else $error("result changed after completion");

   p_phase_needs_done_r5: assert property (@(posedge clk) disable iff (rst)
      status_o[PHASE_BIT] |-> status_o[DONE_BIT])
      else $error("phase set without completion");

   p_done_needs_start_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(status_o[DONE_BIT]) |-> $past(start_i))
      else $error("completion without armed start");

endmodule

bind frame_offset_meter fam_checker #(
   .OFFSET_W(OFFSET_W),
   .STATUS_W(STATUS_W)
) u_fam_checker (
   .clk(clk),
   .rst(rst),
   .start_i(start_i),
   .status_o(status_o)
);

// File: tb/frame_offset_meter_tb_top.sv
module frame_offset_meter_tb_top;

   localparam int HALF = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sclk_i = 1'b0;
   logic        frame_i = 1'b0;
   logic        fe_i = 1'b0;
   logic        start_i = 1'b0;
   logic        gci_mode_i = 1'b0;
   logic [15:0] status_o;

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q [$];
   int n_vec  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   frame_offset_meter dut_i (
      .clk(clk), .rst(rst), .sclk_i(sclk_i), .frame_i(frame_i), .fe_i(fe_i),
      .start_i(start_i), .gci_mode_i(gci_mode_i), .status_o(status_o)
   );

   // monitor: pop expected words and compare against the output
   initial begin
      forever begin
         wait (sb_q.size() != 0);
         @(negedge clk);
         begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (status_o !== it.exp) begin
               n_fail++;
               $display("FAIL %s: status=%h expected=%h", it.tag, status_o, it.exp);
            end
         end
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic expect_word(input logic [15:0] exp, input string tag);
      sb_item_t it;
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
      @(negedge clk);
   endtask

   function automatic logic [15:0] word(input int off, input bit ph);
      return {3'b000, 1'b1, ph, off[10:0]};
   endfunction

   // drive ncyc serial-clock cycles, frame boundary at cycle 'fr', fe events
   task automatic run_frame(input int fr, input int ncyc,
                            input int ev_cyc [4], input bit ev_hi [4],
                            input logic ev_val [4]);
      for (int c = 0; c < ncyc; c++) begin
         for (int s = 0; s < 2*HALF; s++) begin
            @(negedge clk);
            sclk_i  = (s < HALF);
            frame_i = (c == fr) && (s < HALF);
            for (int e = 0; e < 4; e++)
               if (ev_cyc[e] == c && ((ev_hi[e] && s == 1) || (!ev_hi[e] && s == HALF+1)))
                  fe_i = ev_val[e];
         end
      end
      sclk_i  = 1'b0;
      frame_i = 1'b0;
   endtask

   task automatic setup(input logic mode, input logic fe_idle);
      start_i = 1'b0;
      tick(4);
      gci_mode_i = mode;
      fe_i = fe_idle;
      tick(8);
      start_i = 1'b1;
      tick(3);
   endtask

   initial begin
      tick(3);
      rst = 1'b0;
      tick(2);
      expect_word(16'h0000, "R1 reset word");

      // ST-BUS: fall at cycle 6, clock low
      setup(1'b0, 1'b1);
      run_frame(0, 10, '{6, -1, -1, -1}, '{0, 0, 0, 0}, '{1'b0, 1'b0, 1'b0, 1'b0});
      tick(6);
      expect_word(word(6, 1'b0), "R2 R4 R5 stbus off6 low");

      start_i = 1'b0;
      tick(4);
      expect_word(16'h0000, "R8 clear after start fall");

      // GCI: rise at cycle 9, clock high
      setup(1'b1, 1'b0);
      run_frame(0, 12, '{9, -1, -1, -1}, '{1, 0, 0, 0}, '{1'b1, 1'b0, 1'b0, 1'b0});
      tick(6);
      expect_word(word(9, 1'b1), "R3 R4 gci off9 high");
      start_i = 1'b0;
      tick(4);
      expect_word(16'h0000, "R8 clear after gci result");

      // ST-BUS: ignored rise, captured fall at 10 high, later edges ignored
      setup(1'b0, 1'b0);
      run_frame(0, 11, '{3, 10, -1, -1}, '{1, 1, 0, 0}, '{1'b1, 1'b0, 1'b0, 1'b0});
      tick(6);
      expect_word(word(10, 1'b1), "R10 R4 stbus rise ignored off10 high");
      run_frame(-1, 8, '{2, 5, -1, -1}, '{0, 0, 0, 0}, '{1'b1, 1'b0, 1'b0, 1'b0});
      tick(6);
      expect_word(word(10, 1'b1), "R6 later edges ignored");

      // GCI: edges before boundary ignored, edge in boundary cycle -> 0
      setup(1'b1, 1'b0);
      run_frame(3, 6, '{1, 2, 3, -1}, '{1, 1, 0, 0}, '{1'b1, 1'b0, 1'b1, 1'b0});
      tick(6);
      expect_word(word(0, 1'b0), "R7 pre-boundary ignored off0 low");
      start_i = 1'b0;
      tick(4);

      // saturation without edge: expires
      setup(1'b0, 1'b1);
      run_frame(0, 2052, '{-1, -1, -1, -1}, '{0, 0, 0, 0}, '{1'b0, 1'b0, 1'b0, 1'b0});
      tick(6);
      expect_word(16'h0000, "R9 expired no flag");
      run_frame(0, 5, '{2, -1, -1, -1}, '{0, 0, 0, 0}, '{1'b0, 1'b0, 1'b0, 1'b0});
      tick(6);
      expect_word(16'h0000, "R9 edge after expiry ignored");

      // largest capturable offset
      setup(1'b0, 1'b1);
      run_frame(0, 2049, '{2047, -1, -1, -1}, '{1, 0, 0, 0}, '{1'b0, 1'b0, 1'b0, 1'b0});
      tick(6);
      expect_word(word(2047, 1'b1), "R9 max offset 2047 high");
      expect_word(16'h1FFF & 16'h1FFF, "R1 upper bits zero");
      start_i = 1'b0;
      tick(4);
      expect_word(16'h0000, "R8 clear after max");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: status=%h expected=done", status_o);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule